// File: doc/BRIEF.md
# Resumable NMI Control Unit

This block keeps the machine-level state that lets a core take a non-maskable interrupt and later resume the interrupted context. It owns four control registers: a status register with an enable bit, a saved privilege field and a saved virtualization bit; a resume address; a read-only cause value; and a scratch word for the handler. Software reaches them through a single-cycle CSR port. The register address decode, field layout and read data are all produced here.

The block also decodes the resume instruction. When the core signals a resume from machine mode, the unit presents the return address, the privilege and virtualization mode to restore, and whether the modify-privilege bit of the main status register must be cleared. It re-arms the enable bit on the next clock. A resume attempted from any lower mode is turned into an illegal-instruction request instead.

While the enable bit is zero, the unit masks every pending interrupt, suppresses the modify-privilege data-access override, and steers machine traps to a fixed handler address. Privilege legalization stays outside the block: the raw requested field goes out, and the legal value comes back in the same cycle.

Top module: `rnmi_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the status register and the scratch register read as zero, and the enable bit is zero.
- R2: The enable bit (status bit 3) is set by a CSR write that has bit 3 high. A CSR write never clears it once it is one.
- R3: The saved virtualization bit (status bit 7) takes the written value only while `hyp_present` is high. In any cycle where `hyp_present` is low, it is forced to zero at the next clock edge.
- R4: On a status write, the saved privilege field (status bits 12:11) stores `pp_legal`, which is the legalized form of `pp_raw` (the written bits 12:11).
- R5: All status bits other than 3, 7 and 12:11 read as zero and ignore writes.
- R6: The cause register (address 0x742) always reads as a word with only its most significant bit set. Writes to it have no effect.
- R7: The resume-address register (0x741) stores the written value with bit 0 read as zero. The scratch register (0x740) stores all bits. The status register is at 0x744.
- R8: A resume request while `cur_priv` is machine mode (3) raises `nret_fire` in the same cycle. It also presents the resume address on `nret_pc`, the saved privilege on `nret_priv` and the saved virtualization bit on `nret_virt`. The enable bit reads one after the next clock edge.
- R9: `nret_clr_mprv` is high with `nret_fire` exactly when the saved privilege is not machine mode (3).
- R10: A resume request while `cur_priv` is not machine mode raises `nret_illegal`, keeps `nret_fire` low and leaves the enable bit unchanged.
- R11: While the enable bit is zero, `irq_take` is all zeros and `mprv_eff` is low. While it is one, both pass `irq_pending` and `mprv_in` through.
- R12: `trap_pc` equals `RNMI_VEC` (default 0) while the enable bit is zero, and `trap_vec` while it is one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| csr_we | input | 1 | CSR write strobe |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | XLEN | CSR write data |
| csr_rdata | output | XLEN | CSR read data for `csr_addr` |
| csr_hit | output | 1 | Address selects one of the four registers |
| pp_raw | output | 2 | Requested privilege field, taken from the write data |
| pp_legal | input | 2 | Legalized privilege returned for `pp_raw` |
| hyp_present | input | 1 | Hypervisor support is currently enabled |
| cur_priv | input | 2 | Current privilege mode (0 user, 1 supervisor, 3 machine) |
| nret_req | input | 1 | Resume instruction strobe |
| nret_fire | output | 1 | Resume accepted |
| nret_illegal | output | 1 | Resume rejected as an illegal instruction |
| nret_pc | output | XLEN | Address to resume at |
| nret_priv | output | 2 | Privilege to restore |
| nret_virt | output | 1 | Virtualization mode to restore |
| nret_clr_mprv | output | 1 | Clear the main status modify-privilege bit |
| irq_pending | input | NIRQ | Pending interrupt lines |
| irq_take | output | NIRQ | Interrupts allowed to be taken |
| mprv_in | input | 1 | Modify-privilege bit of the main status register |
| mprv_eff | output | 1 | Modify-privilege bit as it applies to data accesses |
| trap_vec | input | XLEN | Normal machine trap target |
| trap_pc | output | XLEN | Selected machine trap target |

## Verification
Read data, decode outputs and gating outputs depend combinationally on the current register state, so they are due in the same cycle as their inputs. Register updates from a CSR write, a resume or a low `hyp_present` are due one clock edge later. The bench drives inputs on the falling edge and samples outputs on the following falling edge. For stored effects, it commits a write on one rising edge and reads the register back on the next falling edge, after exactly one register stage.

// File: rtl/rnmi_pkg.sv
// Package: shared privilege encoding, CSR addresses and status field positions
// for the resumable NMI control unit.
package rnmi_pkg;
    typedef enum logic [1:0] {
        PRIV_USER    = 2'd0,
        PRIV_SUPER   = 2'd1,
        PRIV_RSVD    = 2'd2,
        PRIV_MACHINE = 2'd3
    } priv_e;

    localparam logic [11:0] ADR_SCRATCH = 12'h740;
    localparam logic [11:0] ADR_RESUME  = 12'h741;
    localparam logic [11:0] ADR_CAUSE   = 12'h742;
    localparam logic [11:0] ADR_STATUS  = 12'h744;

    localparam int BIT_ARM  = 3;
    localparam int BIT_VIRT = 7;
    localparam int BIT_PPLO = 11;
    localparam int BIT_PPHI = 12;
endpackage

// File: rtl/rnmi_status.sv
// Module: status register holding the enable bit, saved virtualization bit and
// saved privilege field.
// Assumes the legalized privilege arrives combinationally in the write cycle.
module rnmi_status (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       wr_arm,
    input  logic       wr_virt,
    input  logic [1:0] pp_legal,
    input  logic       hyp_present,
    input  logic       nret_set,
    output logic       arm,
    output logic       virt,
    output logic [1:0] prev_pp
);
    // Enable bit: set-only from software or a resume, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            arm <= 1'b0;
        else if ((wr_en && wr_arm) || nret_set)
            arm <= 1'b1;
    end

    // Saved virtualization bit: writable only while hypervisor support is present.
    always_ff @(posedge clk) begin
        if (!rst_n || !hyp_present)
            virt <= 1'b0;
        else if (wr_en)
            virt <= wr_virt;
    end

    // Saved privilege field: takes the legalized value on a write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            prev_pp <= 2'd0;
        else if (wr_en)
            prev_pp <= pp_legal;
    end

    // R2
    nmie_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> arm);
    // R3
    mnpv_nohyp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hyp_present |=> !virt);
    // R4
    mnpp_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> prev_pp == $past(pp_legal));
endmodule

// File: rtl/rnmi_csr_regs.sv
// Module: resume-address and scratch storage, plus the read multiplexer for
// all four registers.
// Assumes the status fields come from rnmi_status.
module rnmi_csr_regs #(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            csr_we,
    input  logic [11:0]     csr_addr,
    input  logic [XLEN-1:0] csr_wdata,
    input  logic            arm,
    input  logic            virt,
    input  logic [1:0]      prev_pp,
    output logic [XLEN-1:0] resume_pc,
    output logic [XLEN-1:0] rdata,
    output logic            hit
);
    import rnmi_pkg::*;

    localparam logic [XLEN-1:0] CAUSE_VAL = {1'b1, {(XLEN-1){1'b0}}};

    logic [XLEN-1:0] scratch_q;
    logic [XLEN-1:0] status_img;

    // Scratch word: plain read/write storage.
    always_ff @(posedge clk) begin
        if (!rst_n)
            scratch_q <= '0;
        else if (csr_we && csr_addr == ADR_SCRATCH)
            scratch_q <= csr_wdata;
    end

    // Resume address: bit 0 dropped on every write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            resume_pc <= '0;
        else if (csr_we && csr_addr == ADR_RESUME)
            resume_pc <= {csr_wdata[XLEN-1:1], 1'b0};
    end

    // Status image: only the defined fields are visible.
    always_comb begin
        status_img = '0;
        status_img[BIT_ARM] = arm;
        status_img[BIT_VIRT] = virt;
        status_img[BIT_PPHI:BIT_PPLO] = prev_pp;
    end

    // Read multiplexer and address hit.
    always_comb begin
        hit = 1'b1;
        unique case (csr_addr)
            ADR_SCRATCH: rdata = scratch_q;
            ADR_RESUME:  rdata = resume_pc;
            ADR_CAUSE:   rdata = CAUSE_VAL;
            ADR_STATUS:  rdata = status_img;
            default: begin
                rdata = '0;
                hit = 1'b0;
            end
        endcase
    end

    // R7
    epc_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_we && csr_addr == ADR_RESUME) |=> !resume_pc[0]);
endmodule

// File: rtl/rnmi_gate.sv
// Module: gates interrupts, the modify-privilege override and the trap target
// with the enable bit.
// Assumes the trap vector input is already fully formed.
module rnmi_gate #(
    parameter int              XLEN     = 32,
    parameter int              NIRQ     = 16,
    parameter logic [XLEN-1:0] RNMI_VEC = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            arm,
    input  logic [NIRQ-1:0] irq_pending,
    output logic [NIRQ-1:0] irq_take,
    input  logic            mprv_in,
    output logic            mprv_eff,
    input  logic [XLEN-1:0] trap_vec,
    output logic [XLEN-1:0] trap_pc
);
    // Per-line interrupt masking.
    for (genvar g = 0; g < NIRQ; g++) begin : g_irq
        assign irq_take[g] = irq_pending[g] & arm;
    end

    // Modify-privilege override only applies while armed.
    assign mprv_eff = mprv_in & arm;

    // Trap target select.
    assign trap_pc = arm ? trap_vec : RNMI_VEC;

    // R11
    gate_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !arm |-> (irq_take == '0) && !mprv_eff);
    // R12
    rnmi_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !arm |-> trap_pc == RNMI_VEC);
endmodule

// File: rtl/rnmi_ctrl.sv
// Module: top of the resumable NMI control unit. It decodes the resume
// instruction and ties together the status register, the CSR storage and the
// gating logic.
// Assumes a single-cycle CSR port and one resume strobe per instruction.
module rnmi_ctrl #(
    parameter int              XLEN     = 32,
    parameter int              NIRQ     = 16,
    parameter logic [XLEN-1:0] RNMI_VEC = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            csr_we,
    input  logic [11:0]     csr_addr,
    input  logic [XLEN-1:0] csr_wdata,
    output logic [XLEN-1:0] csr_rdata,
    output logic            csr_hit,
    output logic [1:0]      pp_raw,
    input  logic [1:0]      pp_legal,
    input  logic            hyp_present,
    input  logic [1:0]      cur_priv,
    input  logic            nret_req,
    output logic            nret_fire,
    output logic            nret_illegal,
    output logic [XLEN-1:0] nret_pc,
    output logic [1:0]      nret_priv,
    output logic            nret_virt,
    output logic            nret_clr_mprv,
    input  logic [NIRQ-1:0] irq_pending,
    output logic [NIRQ-1:0] irq_take,
    input  logic            mprv_in,
    output logic            mprv_eff,
    input  logic [XLEN-1:0] trap_vec,
    output logic [XLEN-1:0] trap_pc
);
    import rnmi_pkg::*;

    logic       arm;
    logic       virt;
    logic [1:0] prev_pp;
    logic       status_we;
    logic       in_machine;

    // Status write decode and raw privilege request.
    assign status_we = csr_we && (csr_addr == ADR_STATUS);
    assign pp_raw    = csr_wdata[BIT_PPHI:BIT_PPLO];

    // Resume decode: machine mode only.
    assign in_machine    = (cur_priv == PRIV_MACHINE);
    assign nret_fire     = nret_req && in_machine;
    assign nret_illegal  = nret_req && !in_machine;
    assign nret_priv     = prev_pp;
    assign nret_virt     = virt;
    assign nret_clr_mprv = nret_fire && (prev_pp != PRIV_MACHINE);

    rnmi_status u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (status_we),
        .wr_arm      (csr_wdata[BIT_ARM]),
        .wr_virt     (csr_wdata[BIT_VIRT]),
        .pp_legal    (pp_legal),
        .hyp_present (hyp_present),
        .nret_set    (nret_fire),
        .arm         (arm),
        .virt        (virt),
        .prev_pp     (prev_pp)
    );

    rnmi_csr_regs #(.XLEN(XLEN)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .csr_we     (csr_we),
        .csr_addr   (csr_addr),
        .csr_wdata  (csr_wdata),
        .arm        (arm),
        .virt       (virt),
        .prev_pp    (prev_pp),
        .resume_pc  (nret_pc),
        .rdata      (csr_rdata),
        .hit        (csr_hit)
    );

    rnmi_gate #(.XLEN(XLEN), .NIRQ(NIRQ), .RNMI_VEC(RNMI_VEC)) u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .arm         (arm),
        .irq_pending (irq_pending),
        .irq_take    (irq_take),
        .mprv_in     (mprv_in),
        .mprv_eff    (mprv_eff),
        .trap_vec    (trap_vec),
        .trap_pc     (trap_pc)
    );

    // R8
    nret_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nret_fire |=> arm);
    // R10
    illegal_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nret_illegal && !(status_we && csr_wdata[BIT_ARM])) |=> $stable(arm));
    // R9
    clr_mprv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nret_clr_mprv |-> nret_fire && nret_priv != PRIV_MACHINE);
endmodule

// File: tb/test_rnmi_ctrl.sv
`timescale 1ns/1ps
module test_rnmi_ctrl;
    localparam int XLEN = 32;
    localparam int NIRQ = 16;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            csr_we;
    logic [11:0]     csr_addr;
    logic [XLEN-1:0] csr_wdata;
    logic [XLEN-1:0] csr_rdata;
    logic            csr_hit;
    logic [1:0]      pp_raw;
    logic [1:0]      pp_legal;
    logic            hyp_present;
    logic [1:0]      cur_priv;
    logic            nret_req;
    logic            nret_fire;
    logic            nret_illegal;
    logic [XLEN-1:0] nret_pc;
    logic [1:0]      nret_priv;
    logic            nret_virt;
    logic            nret_clr_mprv;
    logic [NIRQ-1:0] irq_pending;
    logic [NIRQ-1:0] irq_take;
    logic            mprv_in;
    logic            mprv_eff;
    logic [XLEN-1:0] trap_vec;
    logic [XLEN-1:0] trap_pc;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    // Environment legalization model: reserved mode 2 maps to user mode.
    always_comb pp_legal = (pp_raw == 2'd2) ? 2'd0 : pp_raw;

    rnmi_ctrl #(.XLEN(XLEN), .NIRQ(NIRQ)) i_rnmi_ctrl (.*);

    typedef struct packed {
        logic [11:0]     addr;
        logic [XLEN-1:0] wdata;
        logic            hyp;
        logic [XLEN-1:0] exp;
        logic [7:0]      req;
    } vec_t;

    localparam vec_t VECS [10] = '{
        '{12'h744, 32'h0000_1880, 1'b1, 32'h0000_1880, 8'd3},  // R3 R4 mode 3, virt set
        '{12'h744, 32'h0000_1000, 1'b1, 32'h0000_0000, 8'd4},  // R4 reserved mode legalized
        '{12'h744, 32'h0000_0880, 1'b0, 32'h0000_0800, 8'd3},  // R3 virt blocked without hypervisor
        '{12'h744, 32'hFFFF_E777, 1'b1, 32'h0000_0000, 8'd5},  // R5 undefined bits ignored
        '{12'h744, 32'h0000_0008, 1'b1, 32'h0000_0008, 8'd2},  // R2 enable set
        '{12'h744, 32'h0000_0000, 1'b1, 32'h0000_0008, 8'd2},  // R2 enable not cleared
        '{12'h742, 32'h0000_1234, 1'b1, 32'h8000_0000, 8'd6},  // R6 cause constant
        '{12'h741, 32'h0000_1235, 1'b1, 32'h0000_1234, 8'd7},  // R7 resume bit 0 dropped
        '{12'h740, 32'hDEAD_BEEF, 1'b1, 32'hDEAD_BEEF, 8'd7},  // R7 scratch full width
        '{12'h744, 32'h0000_1880, 1'b1, 32'h0000_1888, 8'd4}   // R4 fields with enable kept
    };

    task automatic check(input string req, input logic [XLEN-1:0] act,
                         input logic [XLEN-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic csr_write(input logic [11:0] a, input logic [XLEN-1:0] d);
        @(negedge clk);
        csr_we = 1'b1; csr_addr = a; csr_wdata = d;
        @(negedge clk);
        csr_we = 1'b0; csr_wdata = '0;
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        rst_n = 1'b0; csr_we = 1'b0; csr_addr = 12'h744; csr_wdata = '0;
        hyp_present = 1'b1; cur_priv = 2'd3; nret_req = 1'b0;
        irq_pending = '0; mprv_in = 1'b0; trap_vec = 32'h0000_4000;
        do_reset();

        // R1 reset state, R11 R12 gating while disarmed
        @(negedge clk);
        csr_addr = 12'h744; #1 check("R1 status", csr_rdata, 32'h0);
        csr_addr = 12'h740; #1 check("R1 scratch", csr_rdata, 32'h0);
        irq_pending = 16'h00A5; mprv_in = 1'b1; #1;
        check("R11 irq blocked", {16'h0, irq_take}, 32'h0);
        check("R11 mprv blocked", {31'h0, mprv_eff}, 32'h0);
        check("R12 rnmi vector", trap_pc, 32'h0);

        // Table walk: write, then read back one edge later
        foreach (VECS[i]) begin
            hyp_present = VECS[i].hyp;
            csr_write(VECS[i].addr, VECS[i].wdata);
            csr_addr = VECS[i].addr; #1;
            checks++;
            if (csr_rdata !== VECS[i].exp) begin
                errors++;
                $display("FAIL R%0d row %0d: actual=%h expected=%h",
                         VECS[i].req, i, csr_rdata, VECS[i].exp);
            end
        end

        // R11 R12 pass-through while armed
        #1;
        check("R11 irq passed", {16'h0, irq_take}, 32'h0000_00A5);
        check("R11 mprv passed", {31'h0, mprv_eff}, 32'h1);
        check("R12 normal vector", trap_pc, 32'h0000_4000);

        // R3 forced clear when hypervisor support drops
        @(negedge clk); hyp_present = 1'b0;
        @(negedge clk); hyp_present = 1'b1; csr_addr = 12'h744; #1;
        check("R3 virt forced clear", csr_rdata, 32'h0000_1808);

        // R10 illegal resume from user mode, armed
        cur_priv = 2'd0; nret_req = 1'b1; #1;
        check("R10 illegal raised", {31'h0, nret_illegal}, 32'h1);
        check("R10 no fire", {31'h0, nret_fire}, 32'h0);
        @(negedge clk); nret_req = 1'b0; cur_priv = 2'd3;

        // R10 illegal resume while disarmed leaves enable at zero
        do_reset();
        cur_priv = 2'd1; nret_req = 1'b1;
        @(negedge clk); nret_req = 1'b0; cur_priv = 2'd3;
        csr_addr = 12'h744; #1;
        check("R10 enable unchanged", csr_rdata, 32'h0);

        // R8 R9 resume to user mode
        csr_write(12'h741, 32'h0000_2000);
        nret_req = 1'b1; #1;
        check("R8 fire", {31'h0, nret_fire}, 32'h1);
        check("R8 resume pc", nret_pc, 32'h0000_2000);
        check("R8 restore priv", {30'h0, nret_priv}, 32'h0);
        check("R9 clear mprv to user", {31'h0, nret_clr_mprv}, 32'h1);
        @(negedge clk); nret_req = 1'b0; csr_addr = 12'h744; #1;
        check("R8 enable rearmed", csr_rdata, 32'h0000_0008);

        // R8 R9 resume to machine mode with virtualization
        csr_write(12'h744, 32'h0000_1880);
        nret_req = 1'b1; #1;
        check("R8 restore priv machine", {30'h0, nret_priv}, 32'h3);
        check("R8 restore virt", {31'h0, nret_virt}, 32'h1);
        check("R9 keep mprv to machine", {31'h0, nret_clr_mprv}, 32'h0);
        @(negedge clk); nret_req = 1'b0;

        // R7 address decode
        csr_addr = 12'h743; #1;
        check("R7 unmapped miss", {31'h0, csr_hit}, 32'h0);
        csr_addr = 12'h744; #1;
        check("R7 status hit", {31'h0, csr_hit}, 32'h1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000 && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected<=5000 cycles", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule